// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the reservation state for one hart's load-reserved / store-conditional pairs. A load-reserved request that passes its checks installs a reservation covering a naturally aligned 64-byte block. The block also keeps the exact byte address and width that the load touched. A later store-conditional request receives a pass/fail verdict one cycle after it is presented. Every store-conditional that raises no exception, whether it passes or fails, drops the reservation.

Writes seen by the snoop port are judged by source. A store from another hart drops the reservation when it touches any byte of the 64-byte block. A write from a non-hart device drops it only when it overlaps the bytes the load actually read. Requests are also checked for alignment and for the run-time enable of the atomic extension. The block reports the resulting exception cause and, with each response, the register fields decoded from the instruction word.

The control is a two-state machine. `RSV_EMPTY` means no reservation is held. `RSV_HELD` means a reservation is held. The transitions are:
- `LR_INSTALL`: EMPTY→HELD or HELD→HELD, on a clean load-reserved.
- `SC_CONSUME`: HELD→EMPTY, on a clean store-conditional.
- `SNOOP_KILL`: HELD→EMPTY, on a snoop that hits.
- `HOLD`: the state is kept when none of the above applies.

A clean load-reserved in the same cycle as a hitting snoop still installs its reservation.

Top module: `lrsc_reservation_monitor`

## Requirements
- R1: After reset no reservation is held and all response outputs are 0; a store-conditional issued first fails (rsp_sc_fail=1).
- R2: A load-reserved (req_is_sc=0) is aligned when req_addr[1:0]==0 for a word (req_dword=0) or req_addr[2:0]==0 for a doubleword (req_dword=1). An aligned one reserves block req_addr[63:6], and a following aligned store-conditional to any address in that block passes (rsp_sc_fail=0).
- R3: rsp_valid is 1 exactly in the cycle after req_valid=1 and 0 otherwise. With it, rsp_rd=req_insn[11:7], rsp_rs1=req_insn[19:15], rsp_aq=req_insn[26] and rsp_rl=req_insn[25]. All rsp_* are 0 when rsp_valid=0.
- R4: A misaligned request with atomic_en=1 gives rsp_exc_valid=1 and rsp_sc_fail=0. The cause is rsp_exc_cause=4 when misalign_sel=0 and 5 when misalign_sel=1. Such a request neither creates nor clears a reservation.
- R5: With atomic_en=0 any request gives rsp_exc_valid=1 with rsp_exc_cause=2 and leaves the reservation untouched; this check takes priority over alignment.
- R6: A new clean load-reserved replaces any earlier reservation, so a store-conditional to the old block then fails.
- R7: Every clean store-conditional clears the reservation, so a second store-conditional without a new load-reserved fails.
- R8: A snooped hart store (snp_from_hart=1) with snp_addr[63:6] equal to the reserved block clears the reservation; one to another block does not.
- R9: A snooped device write (snp_from_hart=0) covers 2^snp_size naturally aligned bytes from snp_addr. It clears the reservation only if it overlaps the 4 or 8 bytes the load read; otherwise the reservation stays valid.
- R10: A store-conditional in the same cycle as a snoop that hits the reservation fails. A clean load-reserved in the same cycle as a hitting snoop still installs its reservation.
- R11: A clean store-conditional to a block other than the reserved one fails and still clears the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atomic_en | input | 1 | Run-time enable of the atomic extension |
| misalign_sel | input | 1 | Cause for misaligned requests: 0 misaligned (4), 1 access fault (5) |
| req_valid | input | 1 | Request strobe |
| req_is_sc | input | 1 | 1 store-conditional, 0 load-reserved |
| req_dword | input | 1 | 1 doubleword, 0 word |
| req_addr | input | 64 | Request byte address |
| req_insn | input | 32 | Instruction word of the request |
| snp_valid | input | 1 | Snooped write strobe |
| snp_from_hart | input | 1 | 1 store from another hart, 0 device write |
| snp_addr | input | 64 | Snooped write address, aligned to its size |
| snp_size | input | 2 | Log2 of snooped write bytes |
| rsp_valid | output | 1 | Response strobe |
| rsp_sc_fail | output | 1 | Store-conditional verdict, 1 failed |
| rsp_exc_valid | output | 1 | Exception raised |
| rsp_exc_cause | output | 4 | Exception cause code |
| rsp_rd | output | 5 | Destination register field |
| rsp_rs1 | output | 5 | Address register field |
| rsp_aq | output | 1 | Acquire bit |
| rsp_rl | output | 1 | Release bit |

## Verification
The reservation state is hidden, so a wrong state shows up only at the next store-conditional. That is one cycle after the first store-conditional that follows the fault, and it can be arbitrarily later than the fault itself. Some faults cannot be seen until then: a lost device-overlap decision, a stale block address, or a state that survives an exception. The reference model therefore follows every snoop and request, and store-conditionals are placed right after each corner case: same-set non-overlapping device writes, same-cycle snoop and request, and exceptions over a held reservation. A long mixed sequence then keeps stressing that hidden state.

// File: rtl/lrsc_mon_pkg.sv
package lrsc_mon_pkg;
    localparam int ADDR_W  = 64;
    localparam int BLK_LG  = 6;
    localparam int INSN_W  = 32;
    localparam int CAUSE_W = 4;
    localparam int SSZ_W   = 2;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL     = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = 4'd5;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

    typedef struct packed {
        logic [4:0] rd;
        logic [4:0] rs1;
        logic       aq;
        logic       rl;
    } insn_fields_t;
endpackage

// File: rtl/lrsc_req_decode.sv
module lrsc_req_decode
    import lrsc_mon_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = INSN_W
) (
    input  logic               atomic_en,
    input  logic               misalign_sel,
    input  logic               req_valid,
    input  logic               req_is_sc,
    input  logic               req_dword,
    input  logic [AW-1:0]      req_addr,
    input  logic [IW-1:0]      req_insn,
    output logic               lr_go,
    output logic               sc_go,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output insn_fields_t       fields
);
    logic misaligned;
    logic illegal;
    logic unused_insn_bits;

    assign unused_insn_bits = ^{req_insn[IW-1:27], req_insn[24:20],
                                req_insn[14:12], req_insn[6:0],
                                req_addr[AW-1:3]};

    // word needs 4-byte alignment, doubleword needs 8-byte alignment
    assign misaligned = req_dword ? (req_addr[2:0] != 3'b000)
                                  : (req_addr[1:0] != 2'b00);
    assign illegal    = !atomic_en;

    always_comb begin
        exc_valid = req_valid && (illegal || misaligned);
        exc_cause = '0;
        if (req_valid) begin
            if (illegal)
                exc_cause = CAUSE_ILLEGAL;
            else if (misaligned)
                exc_cause = misalign_sel ? CAUSE_LD_FAULT : CAUSE_LD_MISALIGN;
        end
    end

    assign lr_go = req_valid && !exc_valid && !req_is_sc;
    assign sc_go = req_valid && !exc_valid &&  req_is_sc;

    always_comb begin
        fields.rd  = req_insn[11:7];
        fields.rs1 = req_insn[19:15];
        fields.aq  = req_insn[26];
        fields.rl  = req_insn[25];
    end
endmodule

// File: rtl/lrsc_snoop_match.sv
module lrsc_snoop_match
    import lrsc_mon_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int BLG = BLK_LG,
    parameter int SW  = SSZ_W
) (
    input  logic          rsv_held,
    input  logic [AW-1:0] lr_addr,
    input  logic          lr_dword,
    input  logic          snp_valid,
    input  logic          snp_from_hart,
    input  logic [AW-1:0] snp_addr,
    input  logic [SW-1:0] snp_size,
    output logic          snp_kill
);
    localparam int SPAN_W = SW + 1;

    logic [SPAN_W-1:0] lr_lg;
    logic [SPAN_W-1:0] span_lg;
    logic [AW-1:0]     dev_mask;
    logic              hart_hit;
    logic              dev_hit;

    assign lr_lg   = lr_dword ? SPAN_W'(3) : SPAN_W'(2);
    assign span_lg = (SPAN_W'(snp_size) > lr_lg) ? SPAN_W'(snp_size) : lr_lg;

    // both ranges are naturally aligned powers of two: they overlap exactly
    // when their addresses agree above the larger of the two sizes
    for (genvar gi = 0; gi < AW; gi++) begin : g_mask
        assign dev_mask[gi] = (gi >= int'(span_lg));
    end

    assign hart_hit = (snp_addr[AW-1:BLG] == lr_addr[AW-1:BLG]);
    assign dev_hit  = (((snp_addr ^ lr_addr) & dev_mask) == '0);

    assign snp_kill = snp_valid && rsv_held && (snp_from_hart ? hart_hit : dev_hit);
endmodule

// File: rtl/lrsc_rsv_fsm.sv
module lrsc_rsv_fsm
    import lrsc_mon_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int BLG = BLK_LG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_dword,
    input  logic [AW-1:0]      req_addr,
    input  logic               lr_go,
    input  logic               sc_go,
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  insn_fields_t       fields,
    input  logic               snp_kill,
    output logic               rsv_held,
    output logic [AW-1:0]      rsv_addr,
    output logic               rsv_dword,
    output logic               rsp_valid,
    output logic               rsp_sc_fail,
    output logic               rsp_exc_valid,
    output logic [CAUSE_W-1:0] rsp_exc_cause,
    output insn_fields_t       rsp_fields
);
    rsv_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          dword_q;
    logic          blk_eq;
    logic          sc_pass;

    assign blk_eq  = (req_addr[AW-1:BLG] == addr_q[AW-1:BLG]);
    assign sc_pass = (state_q == RSV_HELD) && blk_eq && !snp_kill;

    // next state: LR_INSTALL, SC_CONSUME, SNOOP_KILL, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (lr_go) state_d = RSV_HELD;
            end
            RSV_HELD: begin
                if (lr_go)                  state_d = RSV_HELD;
                else if (sc_go || snp_kill) state_d = RSV_EMPTY;
            end
        endcase
    end

    // state register with the reservation it owns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
            dword_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (lr_go) begin
                addr_q  <= req_addr;
                dword_q <= req_dword;
            end
        end
    end

    // registered response, one cycle after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_sc_fail   <= 1'b0;
            rsp_exc_valid <= 1'b0;
            rsp_exc_cause <= '0;
            rsp_fields    <= '0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_sc_fail   <= sc_go && !sc_pass;
            rsp_exc_valid <= exc_valid;
            rsp_exc_cause <= exc_valid ? exc_cause : '0;
            rsp_fields    <= req_valid ? fields : '0;
        end
    end

    assign rsv_held  = (state_q == RSV_HELD);
    assign rsv_addr  = addr_q;
    assign rsv_dword = dword_q;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R3
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_sc_fail && !rsp_exc_valid)); // R3
    AST_EXC_KEEPS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !snp_kill) |=> ($stable(state_q) && $stable(addr_q))); // R4
    AST_VERDICT_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_fail |-> !rsp_exc_valid); // R4
    AST_LR_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
        lr_go |=> (state_q == RSV_HELD)); // R6
    AST_SC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        sc_go |=> (state_q == RSV_EMPTY)); // R7
    AST_SNOOP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_kill && !lr_go) |=> (state_q == RSV_EMPTY)); // R8
    AST_SNOOP_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_kill && sc_go) |=> rsp_sc_fail); // R10
endmodule

// File: rtl/lrsc_reservation_monitor.sv
module lrsc_reservation_monitor
    import lrsc_mon_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int BLG = BLK_LG,
    parameter int IW  = INSN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               atomic_en,
    input  logic               misalign_sel,
    input  logic               req_valid,
    input  logic               req_is_sc,
    input  logic               req_dword,
    input  logic [AW-1:0]      req_addr,
    input  logic [IW-1:0]      req_insn,
    input  logic               snp_valid,
    input  logic               snp_from_hart,
    input  logic [AW-1:0]      snp_addr,
    input  logic [SSZ_W-1:0]   snp_size,
    output logic               rsp_valid,
    output logic               rsp_sc_fail,
    output logic               rsp_exc_valid,
    output logic [CAUSE_W-1:0] rsp_exc_cause,
    output logic [4:0]         rsp_rd,
    output logic [4:0]         rsp_rs1,
    output logic               rsp_aq,
    output logic               rsp_rl
);
    logic               lr_go, sc_go, exc_valid, snp_kill;
    logic [CAUSE_W-1:0] exc_cause;
    insn_fields_t       fields, rsp_fields;
    logic               rsv_held, rsv_dword;
    logic [AW-1:0]      rsv_addr;

    lrsc_req_decode #(.AW(AW), .IW(IW)) i_decode (
        .atomic_en    (atomic_en),
        .misalign_sel (misalign_sel),
        .req_valid    (req_valid),
        .req_is_sc    (req_is_sc),
        .req_dword    (req_dword),
        .req_addr     (req_addr),
        .req_insn     (req_insn),
        .lr_go        (lr_go),
        .sc_go        (sc_go),
        .exc_valid    (exc_valid),
        .exc_cause    (exc_cause),
        .fields       (fields)
    );

    lrsc_snoop_match #(.AW(AW), .BLG(BLG), .SW(SSZ_W)) i_snoop (
        .rsv_held      (rsv_held),
        .lr_addr       (rsv_addr),
        .lr_dword      (rsv_dword),
        .snp_valid     (snp_valid),
        .snp_from_hart (snp_from_hart),
        .snp_addr      (snp_addr),
        .snp_size      (snp_size),
        .snp_kill      (snp_kill)
    );

    lrsc_rsv_fsm #(.AW(AW), .BLG(BLG)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_dword     (req_dword),
        .req_addr      (req_addr),
        .lr_go         (lr_go),
        .sc_go         (sc_go),
        .exc_valid     (exc_valid),
        .exc_cause     (exc_cause),
        .fields        (fields),
        .snp_kill      (snp_kill),
        .rsv_held      (rsv_held),
        .rsv_addr      (rsv_addr),
        .rsv_dword     (rsv_dword),
        .rsp_valid     (rsp_valid),
        .rsp_sc_fail   (rsp_sc_fail),
        .rsp_exc_valid (rsp_exc_valid),
        .rsp_exc_cause (rsp_exc_cause),
        .rsp_fields    (rsp_fields)
    );

    assign rsp_rd  = rsp_fields.rd;
    assign rsp_rs1 = rsp_fields.rs1;
    assign rsp_aq  = rsp_fields.aq;
    assign rsp_rl  = rsp_fields.rl;
endmodule

// File: tb/test_lrsc_reservation_monitor.sv
module test_lrsc_reservation_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        atomic_en = 1'b1, misalign_sel = 1'b0;
    logic        req_valid = 1'b0, req_is_sc = 1'b0, req_dword = 1'b0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_insn = '0;
    logic        snp_valid = 1'b0, snp_from_hart = 1'b0;
    logic [63:0] snp_addr = '0;
    logic [1:0]  snp_size = '0;
    logic        rsp_valid, rsp_sc_fail, rsp_exc_valid, rsp_aq, rsp_rl;
    logic [3:0]  rsp_exc_cause;
    logic [4:0]  rsp_rd, rsp_rs1;

    int vectors = 0;
    int errors  = 0;

    // behavioural reference state
    bit              m_held = 0;
    longint unsigned m_addr = 0;
    bit              m_dw = 0;
    logic [19:0]     exp_vec = '0;

    always #5 clk = ~clk;

    lrsc_reservation_monitor i_lrsc_reservation_monitor (
        .clk(clk), .rst_n(rst_n), .atomic_en(atomic_en), .misalign_sel(misalign_sel),
        .req_valid(req_valid), .req_is_sc(req_is_sc), .req_dword(req_dword),
        .req_addr(req_addr), .req_insn(req_insn), .snp_valid(snp_valid),
        .snp_from_hart(snp_from_hart), .snp_addr(snp_addr), .snp_size(snp_size),
        .rsp_valid(rsp_valid), .rsp_sc_fail(rsp_sc_fail), .rsp_exc_valid(rsp_exc_valid),
        .rsp_exc_cause(rsp_exc_cause), .rsp_rd(rsp_rd), .rsp_rs1(rsp_rs1),
        .rsp_aq(rsp_aq), .rsp_rl(rsp_rl)
    );

    function automatic bit ranges_meet(longint unsigned a0, longint unsigned n0,
                                       longint unsigned a1, longint unsigned n1);
        return (a0 < a1 + n1) && (a1 < a0 + n0);
    endfunction

    // drive one cycle of stimulus, predict, then compare after the edge
    task automatic apply(string tag, bit rv, bit sc, bit dw, longint unsigned addr,
                         bit sv, bit sh, longint unsigned sa, int ssz);
        bit hit, mis, exc, pass;
        logic [3:0] cause;
        logic [19:0] got;
        req_valid = rv; req_is_sc = sc; req_dword = dw; req_addr = addr;
        req_insn = $urandom;
        snp_valid = sv; snp_from_hart = sh; snp_addr = sa; snp_size = 2'(ssz);
        hit = 0;
        if (sv && m_held) begin
            if (sh) hit = ranges_meet(sa, 1 << ssz, (m_addr >> 6) << 6, 64);
            else    hit = ranges_meet(sa, 1 << ssz, m_addr, m_dw ? 8 : 4);
        end
        mis   = dw ? (addr % 8 != 0) : (addr % 4 != 0);
        exc   = rv && (!atomic_en || mis);
        cause = !exc ? 4'd0 : (!atomic_en ? 4'd2 : (misalign_sel ? 4'd5 : 4'd4));
        pass  = m_held && ((addr >> 6) == (m_addr >> 6)) && !hit;
        exp_vec = '0;
        if (rv)
            exp_vec = {1'b1, (!exc && sc && !pass), exc, cause,
                       req_insn[11:7], req_insn[19:15], req_insn[26], req_insn[25]};
        if (rv && !exc && !sc) begin
            m_held = 1; m_addr = addr; m_dw = dw;
        end else if ((rv && !exc && sc) || hit) begin
            m_held = 0;
        end
        @(negedge clk);
        got = {rsp_valid, rsp_sc_fail, rsp_exc_valid, rsp_exc_cause,
               rsp_rd, rsp_rs1, rsp_aq, rsp_rl};
        vectors++;
        if (got !== exp_vec) begin
            errors++;
            $display("FAIL %s: got %h expected %h (valid,fail,exc,cause,rd,rs1,aq,rl)",
                     tag, got, exp_vec);
        end
    endtask

    task automatic lr(string tag, bit dw, longint unsigned a);
        apply(tag, 1, 0, dw, a, 0, 0, 0, 0);
    endtask
    task automatic sc(string tag, bit dw, longint unsigned a);
        apply(tag, 1, 1, dw, a, 0, 0, 0, 0);
    endtask
    task automatic snoop(string tag, bit hart, longint unsigned a, int sz);
        apply(tag, 0, 0, 0, 0, 1, hart, a, sz);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply("R1", 0, 0, 0, 0, 0, 0, 0, 0);
        sc("R1", 1, 64'h1000);
        // R2 doubleword and word reservations
        lr("R2", 1, 64'h1000);  sc("R2", 1, 64'h1008);
        sc("R7", 1, 64'h1008);
        lr("R2", 0, 64'h2004);  sc("R2", 0, 64'h203C);
        // R4 misalignment causes, no reservation change
        lr("R4", 1, 64'h3003);  sc("R4", 1, 64'h3000);
        lr("R4", 1, 64'h3000);
        misalign_sel = 1'b1; lr("R4", 0, 64'h4002);
        sc("R4", 1, 64'h3000);
        lr("R4", 1, 64'h3000); sc("R4", 1, 64'h3004); sc("R4", 1, 64'h3000);
        misalign_sel = 1'b0;
        // R5 extension disabled
        lr("R5", 1, 64'h5000);
        atomic_en = 1'b0; sc("R5", 1, 64'h5000); lr("R5", 1, 64'h5003);
        atomic_en = 1'b1; sc("R5", 1, 64'h5000);
        // R6 / R11 replacement and wrong block
        lr("R6", 1, 64'h6000); lr("R6", 1, 64'h7000); sc("R6", 1, 64'h6000);
        sc("R11", 1, 64'h7000);
        lr("R11", 1, 64'h7000); sc("R11", 1, 64'h7040); sc("R11", 1, 64'h7000);
        // R8 hart stores
        lr("R8", 1, 64'h8000); snoop("R8", 1, 64'h8030, 3); sc("R8", 1, 64'h8000);
        lr("R8", 1, 64'h8000); snoop("R8", 1, 64'h8040, 3); sc("R8", 1, 64'h8000);
        // R9 device writes
        lr("R9", 1, 64'h9008); snoop("R9", 0, 64'h9010, 3); sc("R9", 1, 64'h9008);
        lr("R9", 1, 64'h9008); snoop("R9", 0, 64'h900C, 1); sc("R9", 1, 64'h9008);
        lr("R9", 0, 64'h9008); snoop("R9", 0, 64'h900C, 2); sc("R9", 0, 64'h9008);
        lr("R9", 0, 64'h9008); snoop("R9", 0, 64'h900B, 0); sc("R9", 0, 64'h9008);
        lr("R9", 0, 64'h9008); snoop("R9", 0, 64'h9000, 3); sc("R9", 0, 64'h9008);
        // R10 same-cycle races
        lr("R10", 1, 64'hA000);
        apply("R10", 1, 1, 1, 64'hA000, 1, 1, 64'hA010, 3);
        lr("R10", 1, 64'hB000);
        apply("R10", 1, 0, 1, 64'hB000, 1, 1, 64'hB000, 3);
        sc("R10", 1, 64'hB000);
        lr("R10", 1, 64'hC000);
        apply("R10", 1, 1, 1, 64'hC000, 1, 0, 64'hC020, 3);
        // R3 mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int sz;
            sz = $urandom % 4;
            atomic_en    = ($urandom % 16) != 0;
            misalign_sel = $urandom % 2;
            apply("R3", ($urandom % 3) != 0, $urandom % 2, $urandom % 2,
                  64'h4000_0000 + ($urandom % 160),
                  ($urandom % 3) == 0, $urandom % 2,
                  (64'h4000_0000 + ($urandom % 160)) & ~((64'd1 << sz) - 1), sz);
        end
        apply("R3", 0, 0, 0, 0, 0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule